// File: doc/BRIEF.md
# UART Receive Character Queue with Ageing Timeout

This block sits between a serial receiver front end and the register file of a memory-mapped UART. Each received character arrives as a one-cycle push strobe with 8-bit data and two line flags, break and framing error. The block stores it as a tagged entry in a 32-deep first-in first-out queue. A read strobe from the register file pops the oldest entry. A 16-bit receive word is presented combinationally for that register read.

The block keeps a set of status levels for a separate interrupt controller:
- receive-ready, which follows a programmable trigger level and clears only when a read drops the fill below that level;
- data-ready and empty;
- sticky overrun, break-detected and ageing-timeout bits.

The ageing timer flags characters that sit below the trigger level for too long. Its length is a parameter in clock cycles and is meant to cover about eight character times. Software clears the sticky bits with a write-one pulse. A soft clear returns the whole block to its idle state.

Top module: `rx_char_queue`

## Requirements
- R1: The queue holds DEPTH (32) entries. A push that arrives while all 32 are in use is not stored, and it sets the sticky overrun bit `ovr_st`.
- R2: A character pushed while exactly 31 entries are in use is stored with bit 14 (error) and bit 13 (overrun) set in its receive word.
- R3: Popping a non-empty queue returns the oldest entry in push order. The receive word is laid out as follows: bit 15 is character-ready and is always 1, bit 12 is the framing flag, bit 11 is the break flag, bits 7:0 are the data, and bit 14 is set whenever bit 12 or bit 13 is set.
- R4: While the queue is empty, `rd_word` is zero, and a pop strobe changes neither the fill nor the order of later characters.
- R5: Every push, including a dropped one, sets `data_rdy` and clears `q_empty` on the next cycle. A pop that takes the fill to zero clears `data_rdy` and sets `q_empty`.
- R6: After a push, `rx_ready` is set when the new fill is greater than or equal to `trig_lvl`.
- R7: After a pop, `rx_ready` is cleared only when the remaining fill is below `trig_lvl`. Changing `trig_lvl` alone never clears it.
- R8: When `rx_ready` is clear and the queue is not empty, `age_st` sets AGE_CYC cycles after the most recent push or pop. Every push or pop restarts the count.
- R9: The ageing timer does not run while `rx_ready` is set or while the queue is empty.
- R10: A push with `push_brk` set stores an entry with bits 14, 12 and 11 set and zero data, whatever the data input carries, and it sets the sticky `brk_st`.
- R11: A one on `clr_sticky` bit 0, 1 or 2 clears `ovr_st`, `brk_st` or `age_st` respectively. A new setting event in the same cycle takes priority over the clear.
- R12: `soft_clr` empties the queue, stops the timer, sets `q_empty`, and clears `data_rdy`, `rx_ready` and all sticky bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_clr | input | 1 | Synchronous clear of queue, timer and flags |
| push_vld | input | 1 | Character push strobe from the receiver |
| push_data | input | 8 | Received character |
| push_ferr | input | 1 | Framing error flag of the character |
| push_brk | input | 1 | Line break event instead of a character |
| pop_req | input | 1 | Receive data register read strobe |
| trig_lvl | input | CNT_W | Receive trigger level from the FIFO control field |
| clr_sticky | input | 3 | Write-one-to-clear: bit0 overrun, bit1 break, bit2 ageing |
| rd_word | output | 16 | Receive word at the head of the queue, zero when empty |
| rx_ready | output | 1 | Fill reached the trigger level |
| data_rdy | output | 1 | At least one character is held |
| q_empty | output | 1 | Queue is empty |
| ovr_st | output | 1 | Sticky overrun |
| brk_st | output | 1 | Sticky break detected |
| age_st | output | 1 | Sticky ageing timeout |

## Verification
A table of characters mixes plain data, framing errors and breaks that carry stray data. Pushing the whole table and then draining it shows whether ordering and tag packing are right, and whether break data is forced to zero. Fill sequences around the trigger level tell apart set-on-push, clear-on-pop and the hysteresis when the level is raised with no pop. A full 33-character burst separates the overrun tag on the 32nd character from the drop of the 33rd. Timer runs show the exact expiry cycle, the restart on a fresh push, and the timer staying silent while ready or empty.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int WORD_W   = 16;
  localparam int RDY_BIT  = 15;
  localparam int ERR_BIT  = 14;
  localparam int OVR_BIT  = 13;
  localparam int FERR_BIT = 12;
  localparam int BRK_BIT  = 11;

  localparam int CLR_OVR  = 0;
  localparam int CLR_BRK  = 1;
  localparam int CLR_AGE  = 2;

  typedef struct packed {
    logic       err;
    logic       ovr;
    logic       ferr;
    logic       brk;
    logic [7:0] data;
  } rxq_entry_t;

  function automatic logic [WORD_W-1:0] pack_word(rxq_entry_t e);
    logic [WORD_W-1:0] w;
    w           = '0;
    w[RDY_BIT]  = 1'b1;
    w[ERR_BIT]  = e.err;
    w[OVR_BIT]  = e.ovr;
    w[FERR_BIT] = e.ferr;
    w[BRK_BIT]  = e.brk;
    w[7:0]      = e.data;
    return w;
  endfunction

endpackage

// File: rtl/rxq_storage.sv
module rxq_storage
  import rxq_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  rxq_entry_t       wr_entry,
  input  logic             rd_en,
  output rxq_entry_t       head,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nx
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  rxq_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, wr_ptr_nx;
  logic [PTR_W-1:0] rd_ptr, rd_ptr_nx;

  // one register row per slot, written only when selected
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_ptr == PTR_W'(i))) begin
        mem[i] <= wr_entry;
      end
    end
  end

  always_comb begin
    wr_ptr_nx = wr_ptr;
    rd_ptr_nx = rd_ptr;
    count_nx  = count;
    if (flush) begin
      wr_ptr_nx = '0;
      rd_ptr_nx = '0;
      count_nx  = '0;
    end else begin
      if (wr_en) begin
        wr_ptr_nx = (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      end
      if (rd_en) begin
        rd_ptr_nx = (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      end
      if (wr_en && !rd_en) begin
        count_nx = count + 1'b1;
      end else if (!wr_en && rd_en) begin
        count_nx = count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      count  <= count_nx;
    end
  end

  assign head = mem[rd_ptr];

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push_evt,
  input  logic             pop_evt,
  input  logic             drop_evt,
  input  logic             brk_evt,
  input  logic             age_fire,
  input  logic [CNT_W-1:0] cnt_nx,
  input  logic [CNT_W-1:0] trig,
  input  logic [2:0]       clr,
  output logic             rx_ready,
  output logic             data_rdy,
  output logic             q_empty,
  output logic             ovr_st,
  output logic             brk_st,
  output logic             age_st,
  output logic             age_run_ok
);

  logic rdy_nx, dr_nx, emp_nx, ovr_nx, brk_nx, age_nx;

  always_comb begin
    rdy_nx = rx_ready;
    dr_nx  = data_rdy;
    emp_nx = q_empty;
    ovr_nx = drop_evt | (ovr_st & ~clr[CLR_OVR]);
    brk_nx = brk_evt  | (brk_st & ~clr[CLR_BRK]);
    age_nx = age_fire | (age_st & ~clr[CLR_AGE]);
    if (push_evt) begin
      if (cnt_nx >= trig) rdy_nx = 1'b1;
      dr_nx  = 1'b1;
      emp_nx = 1'b0;
    end else if (pop_evt) begin
      if (cnt_nx < trig) rdy_nx = 1'b0;
      if (cnt_nx == '0) begin
        dr_nx  = 1'b0;
        emp_nx = 1'b1;
      end
    end
    if (flush) begin
      rdy_nx = 1'b0;
      dr_nx  = 1'b0;
      emp_nx = 1'b1;
      ovr_nx = 1'b0;
      brk_nx = 1'b0;
      age_nx = 1'b0;
    end
  end

  // timer qualification uses the state that follows this edge
  assign age_run_ok = ~rdy_nx & ~emp_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ready <= 1'b0;
      data_rdy <= 1'b0;
      q_empty  <= 1'b1;
      ovr_st   <= 1'b0;
      brk_st   <= 1'b0;
      age_st   <= 1'b0;
    end else begin
      rx_ready <= rdy_nx;
      data_rdy <= dr_nx;
      q_empty  <= emp_nx;
      ovr_st   <= ovr_nx;
      brk_st   <= brk_nx;
      age_st   <= age_nx;
    end
  end

endmodule

// File: rtl/rxq_age_timer.sv
module rxq_age_timer #(
  parameter  int AGE_CYC = 69440,
  localparam int TW      = (AGE_CYC > 2) ? $clog2(AGE_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic restart,
  input  logic run_ok,
  output logic fire
);

  localparam logic [TW-1:0] LAST = TW'(AGE_CYC - 1);

  logic          run, run_nx;
  logic [TW-1:0] cnt, cnt_nx;

  always_comb begin
    run_nx = run;
    cnt_nx = cnt;
    fire   = 1'b0;
    if (flush) begin
      run_nx = 1'b0;
      cnt_nx = '0;
    end else if (restart) begin
      run_nx = run_ok;
      cnt_nx = '0;
    end else if (run) begin
      if (!run_ok) begin
        run_nx = 1'b0;
      end else if (cnt == LAST) begin
        run_nx = 1'b0;
        fire   = 1'b1;
      end else begin
        cnt_nx = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else begin
      run <= run_nx;
      cnt <= cnt_nx;
    end
  end

endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter  int DEPTH   = 32,
  parameter  int AGE_CYC = 69440,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              push_vld,
  input  logic [7:0]        push_data,
  input  logic              push_ferr,
  input  logic              push_brk,
  input  logic              pop_req,
  input  logic [CNT_W-1:0]  trig_lvl,
  input  logic [2:0]        clr_sticky,
  output logic [WORD_W-1:0] rd_word,
  output logic              rx_ready,
  output logic              data_rdy,
  output logic              q_empty,
  output logic              ovr_st,
  output logic              brk_st,
  output logic              age_st
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_core_n <= rst_s1;
    end
  end

  logic [CNT_W-1:0] fill_cnt, cnt_nx;
  rxq_entry_t       head, new_entry;
  logic             full, ovr_tag, push_acc, pop_ok, drop_evt;
  logic             restart, age_fire, age_run_ok;

  assign full     = (fill_cnt == CNT_W'(DEPTH));
  assign ovr_tag  = (fill_cnt == CNT_W'(DEPTH - 1));
  assign push_acc = push_vld & ~full & ~soft_clr;
  assign pop_ok   = pop_req & (fill_cnt != '0) & ~soft_clr;
  assign drop_evt = push_vld & full;
  assign restart  = push_vld | pop_ok;

  always_comb begin
    new_entry.ovr = ovr_tag;
    if (push_brk) begin
      new_entry.data = '0;
      new_entry.brk  = 1'b1;
      new_entry.ferr = 1'b1;
      new_entry.err  = 1'b1;
    end else begin
      new_entry.data = push_data;
      new_entry.brk  = 1'b0;
      new_entry.ferr = push_ferr;
      new_entry.err  = push_ferr | ovr_tag;
    end
  end

  rxq_storage #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .flush    (soft_clr),
    .wr_en    (push_acc),
    .wr_entry (new_entry),
    .rd_en    (pop_ok),
    .head     (head),
    .count    (fill_cnt),
    .count_nx (cnt_nx)
  );

  rxq_flags #(.CNT_W(CNT_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .flush      (soft_clr),
    .push_evt   (push_vld),
    .pop_evt    (pop_ok),
    .drop_evt   (drop_evt),
    .brk_evt    (push_vld & push_brk),
    .age_fire   (age_fire),
    .cnt_nx     (cnt_nx),
    .trig       (trig_lvl),
    .clr        (clr_sticky),
    .rx_ready   (rx_ready),
    .data_rdy   (data_rdy),
    .q_empty    (q_empty),
    .ovr_st     (ovr_st),
    .brk_st     (brk_st),
    .age_st     (age_st),
    .age_run_ok (age_run_ok)
  );

  rxq_age_timer #(.AGE_CYC(AGE_CYC)) u_age (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .flush   (soft_clr),
    .restart (restart),
    .run_ok  (age_run_ok),
    .fire    (age_fire)
  );

  assign rd_word = (fill_cnt != '0) ? pack_word(head) : '0;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_clr,
  input logic             push_vld,
  input logic             push_brk,
  input logic             pop_req,
  input logic [2:0]       clr_sticky,
  input logic [CNT_W-1:0] fill_cnt,
  input logic [15:0]      rd_word,
  input logic             rx_ready,
  input logic             data_rdy,
  input logic             q_empty,
  input logic             ovr_st,
  input logic             brk_st,
  input logic             age_st
);

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(DEPTH));

  assert_full_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && fill_cnt == CNT_W'(DEPTH) && !pop_req && !soft_clr)
      |=> (ovr_st && fill_cnt == CNT_W'(DEPTH)));

  assert_empty_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == '0) |-> (rd_word == 16'h0000));

  assert_empty_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty == (fill_cnt == '0));

  assert_push_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && !soft_clr) |=> (data_rdy && !q_empty));

  assert_age_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(age_st) |-> $past(!rx_ready && !q_empty));

  assert_break_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && push_brk && !soft_clr) |=> brk_st);

  assert_clear_all_R12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> (q_empty && !data_rdy && !rx_ready && !age_st && fill_cnt == '0));

  assert_sticky_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_sticky[0] && !push_vld && !soft_clr) |=> !ovr_st);

endmodule

bind rx_char_queue rxq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_clr   (soft_clr),
  .push_vld   (push_vld),
  .push_brk   (push_brk),
  .pop_req    (pop_req),
  .clr_sticky (clr_sticky),
  .fill_cnt   (fill_cnt),
  .rd_word    (rd_word),
  .rx_ready   (rx_ready),
  .data_rdy   (data_rdy),
  .q_empty    (q_empty),
  .ovr_st     (ovr_st),
  .brk_st     (brk_st),
  .age_st     (age_st)
);

// File: tb/tb_rx_char_queue.sv
module tb_rx_char_queue;

  localparam int PERIOD = 10;
  localparam int DEPTH  = 32;
  localparam int AGE    = 40;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  // {data[25:18], ferr[17], brk[16], expected word[15:0]}
  localparam logic [25:0] VEC [8] = '{
    {8'h41, 1'b0, 1'b0, 16'h8041},
    {8'h00, 1'b0, 1'b0, 16'h8000},
    {8'hFF, 1'b1, 1'b0, 16'hD0FF},
    {8'h5A, 1'b0, 1'b1, 16'hD800},
    {8'hA5, 1'b0, 1'b0, 16'h80A5},
    {8'h3C, 1'b1, 1'b1, 16'hD800},
    {8'h7E, 1'b1, 1'b0, 16'hD07E},
    {8'h81, 1'b0, 1'b0, 16'h8081}
  };

  logic             clk = 1'b0;
  logic             rst_n, soft_clr, push_vld, push_ferr, push_brk, pop_req;
  logic [7:0]       push_data;
  logic [CNT_W-1:0] trig_lvl;
  logic [2:0]       clr_sticky;
  logic [15:0]      rd_word;
  logic             rx_ready, data_rdy, q_empty, ovr_st, brk_st, age_st;

  int errors = 0;
  int checks = 0;

  always #(PERIOD / 2) clk = ~clk;

  rx_char_queue #(.DEPTH(DEPTH), .AGE_CYC(AGE)) dut (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .push_vld(push_vld),
    .push_data(push_data), .push_ferr(push_ferr), .push_brk(push_brk),
    .pop_req(pop_req), .trig_lvl(trig_lvl), .clr_sticky(clr_sticky),
    .rd_word(rd_word), .rx_ready(rx_ready), .data_rdy(data_rdy),
    .q_empty(q_empty), .ovr_st(ovr_st), .brk_st(brk_st), .age_st(age_st)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic f, input logic b);
    @(negedge clk);
    push_vld = 1'b1; push_data = d; push_ferr = f; push_brk = b;
    @(negedge clk);
    push_vld = 1'b0; push_ferr = 1'b0; push_brk = 1'b0;
  endtask

  task automatic pop(output logic [15:0] w);
    @(negedge clk);
    w = rd_word;
    pop_req = 1'b1;
    @(negedge clk);
    pop_req = 1'b0;
  endtask

  task automatic pulse_clr(input logic [2:0] v);
    @(negedge clk);
    clr_sticky = v;
    @(negedge clk);
    clr_sticky = '0;
  endtask

  task automatic pulse_soft();
    @(negedge clk);
    soft_clr = 1'b1;
    @(negedge clk);
    soft_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] w;
    rst_n = 1'b0; soft_clr = 1'b0; push_vld = 1'b0; push_data = '0;
    push_ferr = 1'b0; push_brk = 1'b0; pop_req = 1'b0;
    trig_lvl = CNT_W'(1); clr_sticky = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // reset state (R5, R12)
    chk("R12 reset empty", q_empty, 1);
    chk("R5 reset data_rdy", data_rdy, 0);
    chk("R12 reset flags", {rx_ready, ovr_st, brk_st, age_st}, 0);
    chk("R4 reset word", rd_word, 0);

    // vector table: push all, then drain in order (R3, R10)
    for (int i = 0; i < 8; i++) push(VEC[i][25:18], VEC[i][17], VEC[i][16]);
    chk("R5 data_rdy after pushes", data_rdy, 1);
    chk("R10 break sticky", brk_st, 1);
    for (int i = 0; i < 8; i++) begin
      pop(w);
      chk($sformatf("R3 vector %0d", i), w, VEC[i][15:0]);
    end
    chk("R5 drained empty", {q_empty, data_rdy}, 2'b10);
    pulse_clr(3'b010);
    chk("R11 break cleared", brk_st, 0);

    // empty read ignored (R4)
    pop(w);
    chk("R4 empty read value", w, 0);
    chk("R4 empty read flags", {q_empty, data_rdy}, 2'b10);
    push(8'h33, 1'b0, 1'b0);
    pop(w);
    chk("R4 order intact after empty read", w, 16'h8033);

    // trigger level (R6, R7)
    trig_lvl = CNT_W'(4);
    for (int i = 0; i < 3; i++) push(8'(i), 1'b0, 1'b0);
    chk("R6 below trigger", rx_ready, 0);
    push(8'h03, 1'b0, 1'b0);
    chk("R6 at trigger", rx_ready, 1);
    pop(w);
    chk("R7 pop below trigger", rx_ready, 0);
    pulse_soft();
    trig_lvl = CNT_W'(2);
    for (int i = 0; i < 3; i++) push(8'(i), 1'b0, 1'b0);
    chk("R6 above trigger", rx_ready, 1);
    trig_lvl = CNT_W'(5);
    idle(2);
    chk("R7 raise level holds ready", rx_ready, 1);
    pop(w);
    chk("R7 pop clears with raised level", rx_ready, 0);

    // soft clear (R12)
    pulse_soft();
    chk("R12 soft clear flags", {q_empty, data_rdy, rx_ready}, 3'b100);
    chk("R12 soft clear word", rd_word, 0);

    // ageing timer expiry and restart (R8)
    trig_lvl = CNT_W'(4);
    push(8'h10, 1'b0, 1'b0);
    idle(AGE - 1);
    chk("R8 before expiry", age_st, 0);
    idle(1);
    chk("R8 at expiry", age_st, 1);
    pulse_clr(3'b100);
    chk("R11 age cleared", age_st, 0);
    push(8'h11, 1'b0, 1'b0);
    idle(20);
    push(8'h12, 1'b0, 1'b0);
    idle(AGE - 1);
    chk("R8 restart delays expiry", age_st, 0);
    idle(1);
    chk("R8 expiry after restart", age_st, 1);

    // timer idle when ready or empty (R9)
    pulse_soft();
    trig_lvl = CNT_W'(1);
    push(8'h20, 1'b0, 1'b0);
    idle(AGE + 5);
    chk("R9 no age while ready", age_st, 0);
    pop(w);
    idle(AGE + 5);
    chk("R9 no age while empty", age_st, 0);

    // overrun tag and drop (R1, R2)
    pulse_soft();
    trig_lvl = CNT_W'(0);
    for (int i = 0; i < DEPTH - 1; i++) push(8'(i), 1'b0, 1'b0);
    chk("R1 no overrun yet", ovr_st, 0);
    push(8'h20, 1'b0, 1'b0);
    push(8'hEE, 1'b0, 1'b0);
    chk("R1 overrun sticky", ovr_st, 1);
    for (int i = 0; i < DEPTH - 1; i++) begin
      pop(w);
      chk($sformatf("R1 drain %0d", i), w, 32'h8000 | i);
    end
    pop(w);
    chk("R2 32nd entry tagged", w, 16'hE020);
    chk("R1 33rd dropped", {q_empty, rd_word}, {1'b1, 16'h0000});
    pulse_clr(3'b001);
    chk("R11 overrun cleared", ovr_st, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule